// File: doc/BRIEF.md
# I2C-Mode Serial Shift Unit

This block is the I2C-mode datapath and event logic of a byte-oriented serial port. It takes synchronised samples of SCL and SDA. On each rising SCL edge it shifts in one bit: eight data bits, most significant bit first, then a ninth acknowledge bit. It copies the received byte into a receive buffer and raises single-cycle event pulses. Baud generation, arbitration and pad drive live in neighbouring blocks.

Two mode inputs set the timing. The event-mode input picks between acknowledge-driven events and plain transmit/receive events. The delay-mode input picks whether the SCL line idles high or low. It also moves the transmit event to the falling edge after the ninth bit. The same two inputs decide when the receive buffer is loaded: once or twice per byte. They also decide how the buffer holds the data bits, as a straight byte or in a packed layout that the read path restores to byte order. A start/stop detect input restarts the bit count and raises a condition event. A read strobe captures the buffer onto the read data port.

Top module: `i2cs_shift_unit`

## Requirements
- R1: After reset, all event outputs are low, `rd_data_o` is zero and `scl_idle_o` is high.
- R2: A pulse on `cond_det_i` gives a one-cycle `cond_irq_o` pulse on the next clock and restarts the bit count, so the next eight rising SCL edges are data bits 1 to 8.
- R3: With `evt_mode_i` = 0, on the ninth rising SCL edge SDA is sampled as the acknowledge bit (0 = ACK, 1 = NACK). A NACK raises `tx_irq_o`. An ACK raises `rx_irq_o` and `xfer_req_o`. Neither is raised at any other SCL edge.
- R4: With `evt_mode_i` = 1 and `dly_mode_i` = 0, `tx_irq_o` pulses at the ninth rising SCL edge, whatever the acknowledge value.
- R5: With `evt_mode_i` = 1 and `dly_mode_i` = 1, `tx_irq_o` pulses at the falling SCL edge after the ninth rising edge, and not at the ninth rising edge itself.
- R6: With `evt_mode_i` = 1, `rx_irq_o` and `xfer_req_o` pulse together at the falling SCL edge that follows the eighth data bit.
- R7: With `evt_mode_i` = 0, the buffer is loaded at the ninth rising edge. A read then returns the data byte in bits 7:0, first received bit in bit 7, and the acknowledge bit in bit 8.
- R8: With `evt_mode_i` = 1 and `dly_mode_i` = 0, the buffer is loaded once, in packed form, at the falling edge after the eighth data bit. A read returns the byte in bits 7:0 in received order, with bit 8 at 0.
- R9: With `evt_mode_i` = 1 and `dly_mode_i` = 1, the buffer is loaded twice. The first load, at the falling edge after the eighth data bit, reads back as the byte with bit 8 at 0. The second load, at the ninth rising edge, reads back as the byte with the acknowledge bit in bit 8.
- R10: `scl_idle_o` equals the inverse of `dly_mode_i`, one clock later.
- R11: Each event pulse lasts exactly one clock, and `tx_irq_o` and `rx_irq_o` are never high in the same cycle.
- R12: `rd_data_o` changes only on the clock after `buf_rd_i` is high, and holds otherwise, including while the buffer is reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| evt_mode_i | input | 1 | Event mode: 0 acknowledge-driven, 1 plain transmit/receive |
| dly_mode_i | input | 1 | Clock-delay mode: 1 moves transmit event and sets low idle |
| cond_det_i | input | 1 | Start or stop condition detected (one-cycle pulse) |
| buf_rd_i | input | 1 | Receive buffer read strobe |
| cond_irq_o | output | 1 | Condition event pulse |
| tx_irq_o | output | 1 | Transmit event pulse |
| rx_irq_o | output | 1 | Receive event pulse |
| xfer_req_o | output | 1 | Data transfer request pulse |
| rd_data_o | output | 9 | Formatted receive buffer contents |
| scl_idle_o | output | 1 | Level SCL rests at between transfers |

## Verification
The assertions assume that SCL is already synchronised and stays at each level for at least one clock. They also assume that SDA is stable on the clock where a rising SCL edge is seen, and that the mode inputs do not change inside a byte. The stimulus holds each SCL level for four clocks. It changes SDA only while SCL is low, and sets the mode inputs before the start pulse that opens each frame. One scenario breaks a frame off halfway with a condition pulse. This shows that the acknowledge events land on the ninth rising edge counted from the restart.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  // Event timing variant chosen by the two mode inputs
  typedef enum logic [1:0] {
    TIM_ACK     = 2'b00,  // acknowledge-driven events
    TIM_DIRECT  = 2'b01,  // plain events, no clock delay
    TIM_DELAYED = 2'b10   // plain events, clock delay
  } timing_t;

  // SCL edges that matter to the byte frame
  typedef struct packed {
    logic rise_data;   // rising edge of one of the data bits
    logic fall_last;   // falling edge ahead of the acknowledge bit
    logic rise_last;   // rising edge of the acknowledge bit
    logic fall_after;  // falling edge after the acknowledge bit
  } scl_evt_t;

  function automatic timing_t decode_timing(input logic evt_mode, input logic dly_mode);
    if (!evt_mode)     return TIM_ACK;
    else if (!dly_mode) return TIM_DIRECT;
    else               return TIM_DELAYED;
  endfunction

endpackage

// File: rtl/i2cs_scl_track.sv
module i2cs_scl_track
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_i,
  input  logic     cond_i,
  output scl_evt_t evt_o
);

  localparam int FRAME_LEN = DATA_W + 1;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] FULL_IDX = CNT_W'(FRAME_LEN);

  logic             scl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise, fall;

  assign rise = scl_i & ~scl_q;
  assign fall = ~scl_i & scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      scl_q <= scl_i;
      if (cond_i)
        cnt_q <= '0;
      else if (rise && cnt_q != FULL_IDX)
        cnt_q <= cnt_q + 1'b1;
      else if (fall && cnt_q == FULL_IDX)
        cnt_q <= '0;
    end
  end

  always_comb begin
    evt_o            = '0;
    evt_o.rise_data  = ~cond_i & rise & (cnt_q < LAST_IDX);
    evt_o.fall_last  = ~cond_i & fall & (cnt_q == LAST_IDX);
    evt_o.rise_last  = ~cond_i & rise & (cnt_q == LAST_IDX);
    evt_o.fall_after = ~cond_i & fall & (cnt_q == FULL_IDX);
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_IDX);

  // R3
  ninth_count_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o.rise_last |=> cnt_q == FULL_IDX);

  // R2
  cond_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cond_i |=> cnt_q == '0);

endmodule

// File: rtl/i2cs_shifter.sv
module i2cs_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_i,
  input  logic              shift_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] sh_q;

  // First received bit ends up in the top position
  always_ff @(posedge clk) begin
    if (rst)
      sh_q <= '0;
    else if (shift_i)
      sh_q <= {sh_q[DATA_W-2:0], sda_i};
  end

  assign data_o = sh_q;

  // R7
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_i |=> sh_q[0] == $past(sda_i));

endmodule

// File: rtl/i2cs_rx_buffer.sv
module i2cs_rx_buffer
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  timing_t           mode_i,
  input  logic              fall_last_i,
  input  logic              rise_last_i,
  input  logic              sda_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_i,
  output logic [DATA_W:0]   rd_data_o
);

  localparam int BUF_W = DATA_W + 1;

  logic [BUF_W-1:0] store_q;
  logic [BUF_W-1:0] plain_word, packed_word, load_word;
  logic [BUF_W-1:0] plain_view, packed_view, read_view;
  logic             load_fall, load_rise, packed_mode, stored_packed_q;

  assign load_fall   = fall_last_i & (mode_i != TIM_ACK);
  assign load_rise   = rise_last_i & (mode_i != TIM_DIRECT);
  assign packed_mode = (mode_i == TIM_DIRECT);

  // Straight layout: byte in the low bits, acknowledge bit on top when known
  assign plain_word = {rise_last_i & sda_i, data_i};

  // Packed layout: first DATA_W-1 bits low, last data bit in the top slot
  generate
    for (genvar i = 0; i < DATA_W - 1; i++) begin : g_pack
      assign packed_word[i]  = data_i[i+1];
      assign packed_view[i+1] = store_q[i];
    end
  endgenerate
  assign packed_word[DATA_W-1] = 1'b0;
  assign packed_word[DATA_W]   = data_i[0];
  assign packed_view[0]        = store_q[DATA_W];
  assign packed_view[DATA_W]   = 1'b0;

  assign plain_view = store_q;
  assign load_word  = packed_mode ? packed_word : plain_word;
  assign read_view  = stored_packed_q ? packed_view : plain_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q         <= '0;
      stored_packed_q <= 1'b0;
    end else if (load_fall | load_rise) begin
      store_q         <= load_word;
      stored_packed_q <= packed_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data_o <= '0;
    else if (rd_i)
      rd_data_o <= read_view;
  end

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rd_data_o));

  // R9
  second_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == TIM_DELAYED && rise_last_i) |=> store_q[DATA_W] == $past(sda_i));

  // R8
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == TIM_DIRECT && rise_last_i) |=> $stable(store_q));

endmodule

// File: rtl/i2cs_event_gen.sv
module i2cs_event_gen
  import i2cs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  timing_t  mode_i,
  input  logic     dly_mode_i,
  input  scl_evt_t evt_i,
  input  logic     cond_i,
  input  logic     sda_i,
  output logic     cond_irq_o,
  output logic     tx_irq_o,
  output logic     rx_irq_o,
  output logic     xfer_req_o,
  output logic     scl_idle_o
);

  logic ack_seen, nack_seen;
  logic tx_d, rx_d, xfer_d;

  assign ack_seen  = evt_i.rise_last & ~sda_i;
  assign nack_seen = evt_i.rise_last &  sda_i;

  always_comb begin
    unique case (mode_i)
      TIM_DIRECT: begin
        tx_d   = evt_i.rise_last;
        rx_d   = evt_i.fall_last;
        xfer_d = evt_i.fall_last;
      end
      TIM_DELAYED: begin
        tx_d   = evt_i.fall_after;
        rx_d   = evt_i.fall_last;
        xfer_d = evt_i.fall_last;
      end
      default: begin
        tx_d   = nack_seen;
        rx_d   = ack_seen;
        xfer_d = ack_seen;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_irq_o <= 1'b0;
      tx_irq_o   <= 1'b0;
      rx_irq_o   <= 1'b0;
      xfer_req_o <= 1'b0;
      scl_idle_o <= 1'b1;
    end else begin
      cond_irq_o <= cond_i;
      tx_irq_o   <= tx_d;
      rx_irq_o   <= rx_d;
      xfer_req_o <= xfer_d;
      scl_idle_o <= ~dly_mode_i;
    end
  end

  // R11
  txrx_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_irq_o && rx_irq_o));

  // R11
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq_o |=> !tx_irq_o);

  // R11
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq_o |=> !rx_irq_o);

  // R2
  cond_irq_chk: assert property (@(posedge clk) disable iff (rst)
    cond_i |=> cond_irq_o);

  // R10
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> scl_idle_o == !$past(dly_mode_i));

endmodule

// File: rtl/i2cs_shift_unit.sv
module i2cs_shift_unit
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            evt_mode_i,
  input  logic            dly_mode_i,
  input  logic            cond_det_i,
  input  logic            buf_rd_i,
  output logic            cond_irq_o,
  output logic            tx_irq_o,
  output logic            rx_irq_o,
  output logic            xfer_req_o,
  output logic [DATA_W:0] rd_data_o,
  output logic            scl_idle_o
);

  timing_t           mode;
  scl_evt_t          evt;
  logic [DATA_W-1:0] shift_data;

  assign mode = decode_timing(evt_mode_i, dly_mode_i);

  i2cs_scl_track #(.DATA_W(DATA_W)) u_track (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_i),
    .cond_i (cond_det_i),
    .evt_o  (evt)
  );

  i2cs_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sda_i   (sda_i),
    .shift_i (evt.rise_data),
    .data_o  (shift_data)
  );

  i2cs_rx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode),
    .fall_last_i (evt.fall_last),
    .rise_last_i (evt.rise_last),
    .sda_i       (sda_i),
    .data_i      (shift_data),
    .rd_i        (buf_rd_i),
    .rd_data_o   (rd_data_o)
  );

  i2cs_event_gen u_evt (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode),
    .dly_mode_i (dly_mode_i),
    .evt_i      (evt),
    .cond_i     (cond_det_i),
    .sda_i      (sda_i),
    .cond_irq_o (cond_irq_o),
    .tx_irq_o   (tx_irq_o),
    .rx_irq_o   (rx_irq_o),
    .xfer_req_o (xfer_req_o),
    .scl_idle_o (scl_idle_o)
  );

  // R6
  xfer_follows_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_req_o |-> rx_irq_o);

  // R3
  tx_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_irq_o && $past(!evt_mode_i)) |-> $past(sda_i));

  // R3
  rx_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_irq_o && $past(!evt_mode_i)) |-> !$past(sda_i));

endmodule

// File: tb/tb_i2cs_shift_unit.sv
module tb_i2cs_shift_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1, sda = 1'b1;
  logic       evt_mode = 1'b0, dly_mode = 1'b0;
  logic       cond_det = 1'b0, buf_rd = 1'b0;
  logic       cond_irq, tx_irq, rx_irq, xfer_req, scl_idle;
  logic [8:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int n_tx = 0, n_rx = 0, n_cond = 0, n_xfer = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2cs_shift_unit #(.DATA_W(8)) dut (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda),
    .evt_mode_i (evt_mode),
    .dly_mode_i (dly_mode),
    .cond_det_i (cond_det),
    .buf_rd_i   (buf_rd),
    .cond_irq_o (cond_irq),
    .tx_irq_o   (tx_irq),
    .rx_irq_o   (rx_irq),
    .xfer_req_o (xfer_req),
    .rd_data_o  (rd_data),
    .scl_idle_o (scl_idle)
  );

  // Pulse counters: each high cycle counts once
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_irq)   n_tx   <= n_tx + 1;
      if (rx_irq)   n_rx   <= n_rx + 1;
      if (cond_irq) n_cond <= n_cond + 1;
      if (xfer_req) n_xfer <= n_xfer + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic scl_set(input logic v);
    @(negedge clk);
    scl = v;
    settle();
  endtask

  task automatic start_cond();
    @(negedge clk);
    cond_det = 1'b1;
    @(negedge clk);
    cond_det = 1'b0;
    settle();
  endtask

  task automatic data_bits(input logic [7:0] d, input int count);
    for (int i = 7; i > 7 - count; i--) begin
      scl_set(1'b0);
      sda = d[i];
      scl_set(1'b1);
    end
  endtask

  task automatic read_buf(output logic [8:0] v);
    @(negedge clk);
    buf_rd = 1'b1;
    @(negedge clk);
    buf_rd = 1'b0;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset();
    chk("R1 tx", tx_irq, 0);
    chk("R1 rx", rx_irq, 0);
    chk("R1 cond", cond_irq, 0);
    chk("R1 xfer", xfer_req, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 idle", scl_idle, 1);
  endtask

  // Acknowledge-driven mode, ACK on the ninth bit
  task automatic t_ack_mode_ack();
    logic [8:0] v;
    evt_mode = 1'b0; dly_mode = 1'b0;
    start_cond();
    chk("R2 cond pulse", n_cond, 1);
    data_bits(8'hA5, 8);
    scl_set(1'b0);
    chk("R3 no rx before ninth rise", n_rx, 0);
    sda = 1'b0;
    scl_set(1'b1);
    chk("R3 rx on ACK", n_rx, 1);
    chk("R3 xfer on ACK", n_xfer, 1);
    chk("R3 no tx on ACK", n_tx, 0);
    read_buf(v);
    chk("R7 ack byte", v, 9'h0A5);
    scl_set(1'b0);
    chk("R11 rx single pulse", n_rx, 1);
  endtask

  // Acknowledge-driven mode, NACK on the ninth bit
  task automatic t_ack_mode_nack();
    logic [8:0] v;
    start_cond();
    data_bits(8'h3C, 8);
    scl_set(1'b0);
    sda = 1'b1;
    scl_set(1'b1);
    chk("R3 tx on NACK", n_tx, 1);
    chk("R3 no rx on NACK", n_rx, 1);
    chk("R3 no xfer on NACK", n_xfer, 1);
    read_buf(v);
    chk("R7 nack in bit 8", v, 9'h13C);
    scl_set(1'b0);
  endtask

  // Plain events, no clock delay: packed buffer
  task automatic t_direct();
    logic [8:0] v;
    evt_mode = 1'b1; dly_mode = 1'b0;
    start_cond();
    chk("R10 idle high", scl_idle, 1);
    data_bits(8'hC3, 8);
    chk("R12 rd_data holds", rd_data, 9'h13C);
    scl_set(1'b0);
    chk("R6 rx at fall", n_rx, 2);
    chk("R6 xfer at fall", n_xfer, 2);
    chk("R4 no tx yet", n_tx, 1);
    read_buf(v);
    chk("R8 packed read", v, 9'h0C3);
    sda = 1'b1;
    scl_set(1'b1);
    chk("R4 tx at ninth rise", n_tx, 2);
    read_buf(v);
    chk("R8 single load", v, 9'h0C3);
    scl_set(1'b0);
    chk("R4 no tx after", n_tx, 2);
  endtask

  // Plain events with clock delay: double load
  task automatic t_delayed();
    logic [8:0] v;
    evt_mode = 1'b1; dly_mode = 1'b1;
    start_cond();
    chk("R10 idle low", scl_idle, 0);
    data_bits(8'h5A, 8);
    scl_set(1'b0);
    chk("R6 rx at fall", n_rx, 3);
    read_buf(v);
    chk("R9 first load", v, 9'h05A);
    sda = 1'b1;
    scl_set(1'b1);
    chk("R5 no tx at ninth rise", n_tx, 2);
    read_buf(v);
    chk("R9 second load", v, 9'h15A);
    scl_set(1'b0);
    chk("R5 tx after ninth", n_tx, 3);
    chk("R11 rx once", n_rx, 3);
  endtask

  // Condition mid-frame restarts the bit count
  task automatic t_restart();
    logic [8:0] v;
    evt_mode = 1'b0; dly_mode = 1'b0;
    start_cond();
    data_bits(8'hF0, 4);
    start_cond();
    chk("R2 second cond", n_cond, 6);
    data_bits(8'h96, 8);
    sda = 1'b0;
    chk("R2 no early ack", n_rx, 3);
    scl_set(1'b0);
    scl_set(1'b1);
    chk("R2 ack after restart", n_rx, 4);
    read_buf(v);
    chk("R2 byte after restart", v, 9'h096);
    scl_set(1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ack_mode_ack();
    t_ack_mode_nack();
    t_direct();
    t_delayed();
    t_restart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule